// File: doc/BRIEF.md
# Memory Region Protection Rule Checker

This block is an access firewall placed in front of a multi-port DRAM controller. Each incoming transaction carries an address, a master ID, a port number and a secure/non-secure attribute. The block compares the transaction against a table of protection rules and returns an accept or reject decision one clock later. Each rule combines a window of 1 MiB address granules, an inclusive master-ID range, a mask of allowed ports, a mask of allowed security attributes and a result bit. When no rule matches, a per-port default bit decides the outcome.

Software never writes a rule directly. It fills three staging registers (bounds, IDs, attributes) and then writes a rule number to the select register with a commit bit, which copies the staging set into that rule. A fetch bit does the reverse and copies a rule into the staging registers so that it can be read back. In the intended setup, one valid accepting rule covers the populated memory for every ID, port and security class, and the default rejects on every port.

Top module: `mem_fw_checker`

## Requirements
- R1: After reset every rule is invalid, the default register is 0 and every staging and select register reads 0, so every transaction is accepted with `dec_hit` low.
- R2: Register map at `cfg_waddr`/`cfg_raddr`: 0 = select (rule number in bits [4:0], bit 5 commit, bit 6 fetch; reads back the number with bits 5 and 6 as 0), 1 = bounds (low granule [11:0], high granule [23:12]), 2 = IDs (low ID [11:0], high ID [23:12]), 3 = attributes (security [1:0], valid [2], port mask [12:3], result [13]), 4 = default (one bit per port, [9:0]). Unmapped bits and addresses 5 to 7 read 0. `cfg_rdata` shows the register at `cfg_raddr` one clock later.
- R3: A select write with bit 5 copies the staging registers into the numbered rule; with bit 6 alone it copies that rule into the staging registers. With both bits set only the commit happens. A rule number of 20 or more makes both commands do nothing.
- R4: A rule can match only if valid, with address bits [31:20] inside [low granule, high granule] and the master ID inside [low ID, high ID], both bounds inclusive.
- R5: A rule also needs the port's bit set in its port mask and the security bit of the attribute set: bit 0 permits secure (`txn_nonsec`=0) and bit 1 permits non-secure (`txn_nonsec`=1) accesses.
- R6: When several rules match, the lowest-numbered one decides: `dec_hit`=1, `dec_rule` is its number and `dec_reject` equals its result bit (0 accepts). Without a hit `dec_rule` is 0.
- R7: When no rule matches, `dec_reject` equals the default register bit selected by the port number.
- R8: A port number of 10 or more never matches a rule and is always rejected.
- R9: `dec_valid`, `dec_hit`, `dec_reject` and `dec_rule` are registered: they describe the transaction presented at the previous clock edge, and are all 0 after an edge without `txn_valid`.
- R10: A transaction presented in the same cycle as a commit is judged by the old rule contents; the new contents apply from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_waddr | input | 3 | Register write address |
| cfg_wdata | input | 32 | Register write data |
| cfg_raddr | input | 3 | Register read address |
| cfg_rdata | output | 32 | Registered read data |
| txn_valid | input | 1 | Transaction present |
| txn_addr | input | 32 | Transaction byte address |
| txn_id | input | 12 | Master ID |
| txn_port | input | 4 | Port number |
| txn_nonsec | input | 1 | 1 for a non-secure access |
| dec_valid | output | 1 | Decision present |
| dec_hit | output | 1 | A rule decided |
| dec_reject | output | 1 | 1 rejects, 0 accepts |
| dec_rule | output | 5 | Number of the deciding rule |

## Verification
The hardest situation to reach is a transaction that several valid rules match at once with different results, restricted by different ports and security classes, because only the full indirect staging-and-commit sequence can build such a table. The bench keeps its own copy of the table, updated by the same register writes it issues, and programs overlapping sets of rules (a narrow accepting rule under a wide rejecting one, and a non-secure-only rule behind a secure-only one) before sweeping granules on both sides of every bound, IDs at their range edges, all ports including illegal numbers, and both security classes. A commit issued in the same cycle as a transaction, and commands carrying out-of-range rule numbers, are driven explicitly and then observed at the decision and read-back ports.

// File: rtl/fwc_pkg.sv
package fwc_pkg;
  localparam int GRAN_W     = 12;
  localparam int ID_W       = 12;
  localparam int PORTS      = 10;
  localparam int PIDX_W     = 4;
  localparam int SEL_W      = 5;
  localparam int COMMIT_BIT = 5;
  localparam int FETCH_BIT  = 6;
  localparam int REG_W      = 32;

  typedef struct packed {
    logic [GRAN_W-1:0] lo_g;
    logic [GRAN_W-1:0] hi_g;
    logic [ID_W-1:0]   lo_id;
    logic [ID_W-1:0]   hi_id;
    logic [1:0]        sec;
    logic              vld;
    logic [PORTS-1:0]  pmask;
    logic              res;
  } rule_t;

  typedef enum logic [2:0] {
    RA_SEL    = 3'd0,
    RA_BOUNDS = 3'd1,
    RA_IDS    = 3'd2,
    RA_ATTR   = 3'd3,
    RA_DFLT   = 3'd4
  } reg_addr_e;

  function automatic logic [REG_W-1:0] pack_pair(input logic [11:0] lo, input logic [11:0] hi);
    return {8'd0, hi, lo};
  endfunction

  function automatic logic [REG_W-1:0] pack_attr(input rule_t r);
    return {{(REG_W-PORTS-4){1'b0}}, r.res, r.pmask, r.vld, r.sec};
  endfunction
endpackage

// File: rtl/fwc_rule_table.sv
module fwc_rule_table
  import fwc_pkg::*;
#(
  parameter int NUM_RULES = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_waddr,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic [2:0]       cfg_raddr,
  output logic [REG_W-1:0] cfg_rdata,
  output rule_t            rules_o [NUM_RULES],
  output logic [PORTS-1:0] dflt_o
);
  rule_t            rules_q [NUM_RULES];
  rule_t            stage_q;
  logic [SEL_W-1:0] sel_q;
  logic [PORTS-1:0] dflt_q;
  logic [REG_W-1:0] rd_next;

  logic [SEL_W-1:0] wsel;
  logic             wsel_ok;
  logic             do_commit;
  logic             do_fetch;

  assign wsel      = cfg_wdata[SEL_W-1:0];
  assign wsel_ok   = 32'(wsel) < NUM_RULES;
  assign do_commit = cfg_we && (cfg_waddr == RA_SEL) && wsel_ok && cfg_wdata[COMMIT_BIT];
  assign do_fetch  = cfg_we && (cfg_waddr == RA_SEL) && wsel_ok && cfg_wdata[FETCH_BIT]
                     && !cfg_wdata[COMMIT_BIT];

  logic unused_wdata;
  assign unused_wdata = ^cfg_wdata[REG_W-1:24];

  // Rule storage: one write port, all entries visible to the matcher.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_RULES; i++) rules_q[i] <= '0;
    end else if (do_commit) begin
      rules_q[wsel] <= stage_q;
    end
  end

  // Staging, select and default registers.
  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      sel_q   <= '0;
      dflt_q  <= '0;
    end else if (cfg_we) begin
      case (cfg_waddr)
        RA_SEL: begin
          sel_q <= wsel;
          if (do_fetch) stage_q <= rules_q[wsel];
        end
        RA_BOUNDS: begin
          stage_q.lo_g <= cfg_wdata[11:0];
          stage_q.hi_g <= cfg_wdata[23:12];
        end
        RA_IDS: begin
          stage_q.lo_id <= cfg_wdata[11:0];
          stage_q.hi_id <= cfg_wdata[23:12];
        end
        RA_ATTR: begin
          stage_q.sec   <= cfg_wdata[1:0];
          stage_q.vld   <= cfg_wdata[2];
          stage_q.pmask <= cfg_wdata[PORTS+2:3];
          stage_q.res   <= cfg_wdata[PORTS+3];
        end
        RA_DFLT: dflt_q <= cfg_wdata[PORTS-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (cfg_raddr)
      RA_SEL:    rd_next = {{(REG_W-SEL_W){1'b0}}, sel_q};
      RA_BOUNDS: rd_next = pack_pair(stage_q.lo_g, stage_q.hi_g);
      RA_IDS:    rd_next = pack_pair(stage_q.lo_id, stage_q.hi_id);
      RA_ATTR:   rd_next = pack_attr(stage_q);
      RA_DFLT:   rd_next = {{(REG_W-PORTS){1'b0}}, dflt_q};
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= rd_next;
  end

  assign rules_o = rules_q;
  assign dflt_o  = dflt_q;
endmodule

// File: rtl/fwc_match.sv
module fwc_match
  import fwc_pkg::*;
#(
  parameter int NUM_RULES = 20,
  localparam int RIDX_W   = $clog2(NUM_RULES)
) (
  input  rule_t             rules_i [NUM_RULES],
  input  logic [PORTS-1:0]  dflt_i,
  input  logic [GRAN_W-1:0] gran_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [PIDX_W-1:0] port_i,
  input  logic              nonsec_i,
  output logic              hit_o,
  output logic [RIDX_W-1:0] idx_o,
  output logic              reject_o
);
  logic [NUM_RULES-1:0] hv;
  logic                 port_ok;
  logic                 dflt_rej;

  assign port_ok  = 32'(port_i) < PORTS;
  assign dflt_rej = port_ok ? dflt_i[port_i] : 1'b1;

  for (genvar g = 0; g < NUM_RULES; g++) begin : g_rule
    rule_t r;
    logic  in_win, in_ids, port_en, sec_en;
    assign r       = rules_i[g];
    assign in_win  = (gran_i >= r.lo_g) && (gran_i <= r.hi_g);
    assign in_ids  = (id_i >= r.lo_id) && (id_i <= r.hi_id);
    assign port_en = port_ok && r.pmask[port_i];
    assign sec_en  = nonsec_i ? r.sec[1] : r.sec[0];
    assign hv[g]   = r.vld && in_win && in_ids && port_en && sec_en;
  end

  // Scan from the top so the lowest-numbered hit is left standing.
  always_comb begin
    hit_o    = 1'b0;
    idx_o    = '0;
    reject_o = dflt_rej;
    for (int i = NUM_RULES - 1; i >= 0; i--) begin
      if (hv[i]) begin
        hit_o    = 1'b1;
        idx_o    = i[RIDX_W-1:0];
        reject_o = rules_i[i].res;
      end
    end
  end
endmodule

// File: rtl/mem_fw_checker.sv
module mem_fw_checker
  import fwc_pkg::*;
#(
  parameter int NUM_RULES = 20,
  parameter int ADDR_W    = 32,
  localparam int RIDX_W   = $clog2(NUM_RULES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_waddr,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic [2:0]        cfg_raddr,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              txn_valid,
  input  logic [ADDR_W-1:0] txn_addr,
  input  logic [ID_W-1:0]   txn_id,
  input  logic [PIDX_W-1:0] txn_port,
  input  logic              txn_nonsec,
  output logic              dec_valid,
  output logic              dec_hit,
  output logic              dec_reject,
  output logic [RIDX_W-1:0] dec_rule
);
  localparam int LOW_W = ADDR_W - GRAN_W;

  rule_t             rules [NUM_RULES];
  logic [PORTS-1:0]  dflt;
  logic              m_hit;
  logic              m_rej;
  logic [RIDX_W-1:0] m_idx;

  logic unused_addr_lo;
  assign unused_addr_lo = ^txn_addr[LOW_W-1:0];

  fwc_rule_table #(.NUM_RULES(NUM_RULES)) u_table (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_waddr (cfg_waddr),
    .cfg_wdata (cfg_wdata),
    .cfg_raddr (cfg_raddr),
    .cfg_rdata (cfg_rdata),
    .rules_o   (rules),
    .dflt_o    (dflt)
  );

  fwc_match #(.NUM_RULES(NUM_RULES)) u_match (
    .rules_i  (rules),
    .dflt_i   (dflt),
    .gran_i   (txn_addr[ADDR_W-1 -: GRAN_W]),
    .id_i     (txn_id),
    .port_i   (txn_port),
    .nonsec_i (txn_nonsec),
    .hit_o    (m_hit),
    .idx_o    (m_idx),
    .reject_o (m_rej)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_hit    <= 1'b0;
      dec_reject <= 1'b0;
      dec_rule   <= '0;
    end else begin
      dec_valid  <= txn_valid;
      dec_hit    <= txn_valid && m_hit;
      dec_reject <= txn_valid && m_rej;
      dec_rule   <= (txn_valid && m_hit) ? m_idx : '0;
    end
  end
endmodule

// File: rtl/fwc_chk.sv
module fwc_chk
  import fwc_pkg::*;
#(
  parameter int NUM_RULES = 20,
  localparam int RIDX_W   = $clog2(NUM_RULES)
) (
  input logic              clk,
  input logic              rst,
  input logic              txn_valid,
  input logic [PIDX_W-1:0] txn_port,
  input logic              dec_valid,
  input logic              dec_hit,
  input logic              dec_reject,
  input logic [RIDX_W-1:0] dec_rule
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> !dec_valid && !dec_hit && !dec_reject);

  // R9
  dec_follow_chk: assert property (@(posedge clk) disable iff (rst) txn_valid |=> dec_valid);

  // R9
  dec_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !txn_valid |=> !dec_valid && !dec_hit && !dec_reject);

  // R6
  rule_range_chk: assert property (@(posedge clk) disable iff (rst)
    dec_hit |-> (32'(dec_rule) < NUM_RULES) && dec_valid);

  // R6
  rule_zero_chk: assert property (@(posedge clk) disable iff (rst) !dec_hit |-> dec_rule == '0);

  // R8
  bad_port_chk: assert property (@(posedge clk) disable iff (rst)
    txn_valid && (32'(txn_port) >= PORTS) |=> dec_reject && !dec_hit);
endmodule

bind mem_fw_checker fwc_chk #(.NUM_RULES(NUM_RULES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .txn_valid  (txn_valid),
  .txn_port   (txn_port),
  .dec_valid  (dec_valid),
  .dec_hit    (dec_hit),
  .dec_reject (dec_reject),
  .dec_rule   (dec_rule)
);

// File: tb/mem_fw_checker_test.sv
module mem_fw_checker_test;
  localparam int NR = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_waddr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [2:0]  cfg_raddr = '0;
  logic [31:0] cfg_rdata;
  logic        txn_valid = 1'b0;
  logic [31:0] txn_addr = '0;
  logic [11:0] txn_id = '0;
  logic [3:0]  txn_port = '0;
  logic        txn_nonsec = 1'b0;
  logic        dec_valid, dec_hit, dec_reject;
  logic [4:0]  dec_rule;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model of the rule table
  logic [11:0] m_lo [NR], m_hi [NR], m_lid [NR], m_hid [NR];
  logic [1:0]  m_sec [NR];
  logic        m_v [NR], m_res [NR];
  logic [9:0]  m_mask [NR];
  logic [9:0]  m_dflt = '0;
  logic [31:0] s_bounds = '0, s_ids = '0, s_attr = '0;

  mem_fw_checker uut (.*);

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    case (a)
      3'd1: s_bounds = d & 32'h00FF_FFFF;
      3'd2: s_ids    = d & 32'h00FF_FFFF;
      3'd3: s_attr   = d & 32'h0000_3FFF;
      3'd4: m_dflt   = d[9:0];
      default: ;
    endcase
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string req);
    cfg_raddr = a;
    @(posedge clk); #1;
    check(cfg_rdata === exp, req, cfg_rdata, exp);
  endtask

  task automatic stage(input int lo, input int hi, input int lid, input int hid,
                       input int sec, input int vld, input int mask, input int res);
    wr(3'd1, 32'((hi << 12) | lo));
    wr(3'd2, 32'((hid << 12) | lid));
    wr(3'd3, 32'(sec | (vld << 2) | (mask << 3) | (res << 13)));
  endtask

  task automatic model_commit(input int idx);
    if (idx < NR) begin
      m_lo[idx] = s_bounds[11:0];  m_hi[idx] = s_bounds[23:12];
      m_lid[idx] = s_ids[11:0];    m_hid[idx] = s_ids[23:12];
      m_sec[idx] = s_attr[1:0];    m_v[idx] = s_attr[2];
      m_mask[idx] = s_attr[12:3];  m_res[idx] = s_attr[13];
    end
  endtask

  task automatic commit(input int idx);
    wr(3'd0, 32'(idx | 32));
    model_commit(idx);
  endtask

  function automatic logic [7:0] exp_dec(input logic [31:0] a, input logic [11:0] id,
                                         input logic [3:0] p, input logic ns);
    logic [11:0] g = a[31:20];
    for (int r = 0; r < NR; r++) begin
      if (m_v[r] && g >= m_lo[r] && g <= m_hi[r] && id >= m_lid[r] && id <= m_hid[r]
          && p < 4'd10 && m_mask[r][p] && (ns ? m_sec[r][1] : m_sec[r][0]))
        return {1'b1, 1'b1, m_res[r], 5'(r)};
    end
    return {1'b1, 1'b0, (p >= 4'd10) ? 1'b1 : m_dflt[p], 5'd0};
  endfunction

  task automatic txn(input logic [31:0] a, input logic [11:0] id, input logic [3:0] p,
                     input logic ns, input string req);
    logic [7:0] e;
    e = exp_dec(a, id, p, ns);
    txn_valid = 1'b1; txn_addr = a; txn_id = id; txn_port = p; txn_nonsec = ns;
    @(posedge clk); #1;
    txn_valid = 1'b0;
    check({dec_valid, dec_hit, dec_reject, dec_rule} === e, req,
          32'({dec_valid, dec_hit, dec_reject, dec_rule}), 32'(e));
  endtask

  task automatic sweep(input string req);
    logic [11:0] grans [6] = '{12'd0, 12'd2, 12'd3, 12'd5, 12'd6, 12'hFFF};
    logic [11:0] ids [5]   = '{12'h000, 12'h00F, 12'h010, 12'h020, 12'h021};
    for (int gi = 0; gi < 6; gi++)
      for (int ii = 0; ii < 5; ii++)
        for (int p = 0; p < 12; p++)
          for (int ns = 0; ns < 2; ns++)
            txn({grans[gi], 20'hA5C3E}, ids[ii], 4'(p), 1'(ns), req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NR; r++) begin
      m_lo[r] = 0; m_hi[r] = 0; m_lid[r] = 0; m_hid[r] = 0;
      m_sec[r] = 0; m_v[r] = 0; m_res[r] = 0; m_mask[r] = 0;
    end
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state, R2 read map
    for (int a = 0; a < 8; a++) rd_chk(3'(a), 32'd0, "R1 reset readback");
    txn(32'h1234_5678, 12'h3, 4'd2, 1'b0, "R1 reset accepts");
    txn(32'hFFF0_0000, 12'hFFF, 4'd9, 1'b1, "R1 reset accepts");

    // R9 idle cycle
    @(posedge clk); #1;
    check({dec_valid, dec_hit, dec_reject, dec_rule} === 8'd0, "R9 idle outputs",
          32'({dec_valid, dec_hit, dec_reject, dec_rule}), 32'd0);

    // R2 field masking and readback
    wr(3'd1, 32'hFFFF_FFFF); rd_chk(3'd1, 32'h00FF_FFFF, "R2 bounds mask");
    wr(3'd2, 32'hABCD_E123); rd_chk(3'd2, 32'h00CD_E123, "R2 ids mask");
    wr(3'd3, 32'hFFFF_FFFF); rd_chk(3'd3, 32'h0000_3FFF, "R2 attr mask");
    wr(3'd4, 32'hFFFF_FFFF); rd_chk(3'd4, 32'h0000_03FF, "R2 default mask");
    wr(3'd0, 32'h0000_0013); rd_chk(3'd0, 32'h0000_0013, "R2 select readback");
    wr(3'd0, 32'h0000_0060 | 32'd25); rd_chk(3'd0, 32'd25, "R2 select drops command bits");
    rd_chk(3'd3, 32'h0000_3FFF, "R3 out-of-range fetch leaves staging");

    // R7 / R8 defaults with no rule
    wr(3'd4, 32'h2A5);
    for (int p = 0; p < 16; p++) txn(32'h0030_0000, 12'h1, 4'(p), 1'b0, "R7 R8 default by port");

    // R3 program and read back rule 0
    stage(2, 5, 12'h010, 12'h020, 3, 1, 12'h3FF, 0);
    commit(0);
    wr(3'd0, 32'(7 | 64));
    rd_chk(3'd1, 32'd0, "R3 fetch empty rule bounds");
    rd_chk(3'd3, 32'd0, "R3 fetch empty rule attr");
    wr(3'd0, 32'(0 | 64));
    rd_chk(3'd1, 32'h0000_5002, "R3 fetch rule0 bounds");
    rd_chk(3'd2, 32'h0002_0010, "R3 fetch rule0 ids");
    rd_chk(3'd3, 32'h0000_1FFF, "R3 fetch rule0 attr");
    s_bounds = 32'h5002; s_ids = 32'h20010; s_attr = 32'h1FFF;

    // R4 windows and ID ranges under reject-all default
    wr(3'd4, 32'h3FF);
    sweep("R4 window and id range");

    // R5 R6 overlapping rules
    stage(0, 12'hFFF, 0, 12'hFFF, 1, 1, 12'h00F, 1); commit(4);
    stage(3, 3, 0, 12'hFFF, 3, 1, 12'h3FF, 0);      commit(2);
    stage(0, 12'hFFF, 0, 12'hFFF, 2, 1, 12'h3F0, 0); commit(9);
    wr(3'd4, 32'h0F0);
    sweep("R5 R6 priority port security");

    // R3 out-of-range commits change nothing
    stage(0, 12'hFFF, 0, 12'hFFF, 3, 1, 12'h3FF, 1);
    wr(3'd0, 32'(20 | 32));
    wr(3'd0, 32'(31 | 32));
    sweep("R3 out-of-range commit ignored");

    // R3 commit with fetch: commit wins, staging unchanged
    stage(6, 6, 12'h100, 12'h1FF, 3, 1, 12'h3FF, 1);
    wr(3'd0, 32'(3 | 32 | 64));
    model_commit(3);
    rd_chk(3'd1, 32'h0000_6006, "R3 commit+fetch staging kept");
    txn(32'h0060_0000, 12'h150, 4'd1, 1'b0, "R3 commit+fetch stored rule 3");
    txn(32'h0060_0000, 12'h200, 4'd1, 1'b0, "R3 rule 3 id bound");

    // R10 commit and transaction in the same cycle
    stage(0, 12'hFFF, 0, 12'hFFF, 3, 1, 12'h3FF, 1);
    begin
      logic [7:0] e_old;
      e_old = exp_dec(32'h0000_0000, 12'h0, 4'd5, 1'b1);
      cfg_we = 1'b1; cfg_waddr = 3'd0; cfg_wdata = 32'(1 | 32);
      txn_valid = 1'b1; txn_addr = 32'h0; txn_id = 12'h0; txn_port = 4'd5; txn_nonsec = 1'b1;
      @(posedge clk); #1;
      cfg_we = 1'b0; txn_valid = 1'b0;
      model_commit(1);
      check({dec_valid, dec_hit, dec_reject, dec_rule} === e_old, "R10 same-cycle uses old rule",
            32'({dec_valid, dec_hit, dec_reject, dec_rule}), 32'(e_old));
    end
    txn(32'h0000_0000, 12'h0, 4'd5, 1'b1, "R10 next cycle uses new rule");
    txn(32'h0030_0000, 12'h015, 4'd0, 1'b0, "R6 rule 0 before rule 1");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule